// File: doc/BRIEF.md
# Physical-Register Ready Tracker with Dependent Wakeup

This block keeps one ready flag for each physical register and remembers which waiting instructions need which registers. The rename/dispatch side inserts an instruction with a tag, up to two source register indices, each with a ready hint, and one destination index. A source that is not ready is looked up in the scoreboard at insertion. If the scoreboard already shows the register ready, the source counts as ready. Otherwise the tag goes onto that register's dependent list, which has a fixed number of slots. The destination register is marked not-ready.

When execution reports a finished destination register, the block drains that register's dependent list, one tag per cycle. Each drained tag gets one source marked ready. A tag whose last source becomes ready appears on the wake output. The register is marked ready once its list is empty.

A squash removes a tag from every list and leaves the scoreboard unchanged. Register indices at or beyond the physical range (integer plus floating-point count) are never tracked.

Top module: `swu_wakeup_unit`

## Requirements
- R1: After reset every in-range scoreboard flag is not-ready. An inserted source at such an index, with its ready hint low, does not produce a wake.
- R2: An insert whose sources are all ready (hint high, scoreboard ready, or out of range) produces `wake_valid` with its tag in the cycle after acceptance.
- R3: A source with its hint low, whose register the scoreboard shows ready, counts as ready at insertion.
- R4: An accepted insert with an in-range destination clears that register's scoreboard flag.
- R5: Indices at or above NUM_INT_REGS+NUM_FP_REGS are treated as ready sources. A completion at such an index is ignored: `busy` stays low and no wake occurs.
- R6: An instruction with two not-ready sources wakes only after both registers have completed.
- R7: `ins_stall` is high when accepting the insert would push a dependent list beyond LIST_DEPTH tags. A same-register pair of sources needs two slots.
- R8: A completion on a register with n queued tags holds `busy` high for exactly n cycles and drains one tag per cycle. With n = 0 it marks the register ready at once.
- R9: A squashed tag is removed from every list, is never woken, and no longer takes a drain cycle.
- R10: `prod_conflict` pulses for one cycle after an insert installs a destination on a register whose dependent list is not empty.
- R11: `ins_stall` is high while `busy`, `cmp_valid` or `sq_valid` is high.
- R12: After its list has drained, the completed register reads as ready to later inserts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ins_valid | input | 1 | Insert request |
| ins_tag | input | TAG_W | Tag of the inserted instruction |
| ins_src0 | input | REG_W | First source register index |
| ins_src0_rdy | input | 1 | First source already ready |
| ins_src1 | input | REG_W | Second source register index |
| ins_src1_rdy | input | 1 | Second source already ready |
| ins_dst | input | REG_W | Destination register index |
| ins_stall | output | 1 | Insert not accepted this cycle |
| cmp_valid | input | 1 | Completion of a destination register (only while busy is low) |
| cmp_dst | input | REG_W | Completed register index |
| sq_valid | input | 1 | Squash request (only while busy is low) |
| sq_tag | input | TAG_W | Tag to remove |
| wake_valid | output | 1 | A tag has all sources ready |
| wake_tag | output | TAG_W | Woken tag |
| busy | output | 1 | A dependent list is being drained |
| prod_conflict | output | 1 | Destination installed on a register with waiting tags |

## Verification
The bench builds the block with four integer and four floating-point registers, a 4-bit index, 3-bit tags and four-slot lists. With these values every register can be swept, and every list fill level from empty to full can be drained. Indices 8 to 15 exercise the untracked range. Eight tags are enough to fill a list completely, to overflow it, and to observe squash and two-source wakeups without reusing a tag that is still waiting.

// File: rtl/swu_pkg.sv
package swu_pkg;
   typedef enum logic {
      DRN_IDLE = 1'b0,
      DRN_RUN  = 1'b1
   } drain_state_e;

   typedef logic [1:0] pend_cnt_t;
endpackage

// File: rtl/swu_dep_list.sv
module swu_dep_list #(
   parameter int TAG_W      = 4,
   parameter int LIST_DEPTH = 4,
   parameter int CNT_W      = $clog2(LIST_DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       push_n,
   input  logic [TAG_W-1:0] push_tag,
   input  logic             pop,
   input  logic             sq_v,
   input  logic [TAG_W-1:0] sq_tag,
   output logic [CNT_W-1:0] cnt,
   output logic [TAG_W-1:0] head_tag,
   output logic             head_v
);
   localparam int IDX_W = (LIST_DEPTH > 1) ? $clog2(LIST_DEPTH) : 1;

   logic [LIST_DEPTH-1:0] v_q, v_n;
   logic [TAG_W-1:0]      t_q [LIST_DEPTH];
   logic [TAG_W-1:0]      t_n [LIST_DEPTH];
   logic [IDX_W-1:0]      head_idx;
   logic [1:0]            rem;

   // lowest occupied slot is the head
   always_comb begin
      head_v   = 1'b0;
      head_idx = '0;
      for (int i = LIST_DEPTH - 1; i >= 0; i--) begin
         if (v_q[i]) begin
            head_v   = 1'b1;
            head_idx = IDX_W'(i);
         end
      end
   end

   assign head_tag = t_q[head_idx];

   always_comb begin
      cnt = '0;
      for (int i = 0; i < LIST_DEPTH; i++) begin
         cnt = cnt + CNT_W'(v_q[i]);
      end
   end

   always_comb begin
      v_n = v_q;
      for (int i = 0; i < LIST_DEPTH; i++) begin
         t_n[i] = t_q[i];
      end
      if (pop) begin
         v_n[head_idx] = 1'b0;
      end
      if (sq_v) begin
         for (int i = 0; i < LIST_DEPTH; i++) begin
            if (v_q[i] && (t_q[i] == sq_tag)) begin
               v_n[i] = 1'b0;
            end
         end
      end
      rem = push_n;
      for (int i = 0; i < LIST_DEPTH; i++) begin
         if (!v_n[i] && (rem != 2'd0)) begin
            v_n[i] = 1'b1;
            t_n[i] = push_tag;
            rem    = rem - 2'd1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_q <= '0;
      end else begin
         v_q <= v_n;
      end
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < LIST_DEPTH; i++) begin
         t_q[i] <= t_n[i];
      end
   end

   // R7: pushes never exceed the free slots
   a_r7_no_overflow : assert property (@(posedge clk) disable iff (!rst_n)
      (int'(cnt) + int'(push_n)) <= LIST_DEPTH);

   // R8: a drain step always finds a queued tag
   a_r8_pop_has_head : assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> head_v);
endmodule

// File: rtl/swu_tag_table.sv
module swu_tag_table
   import swu_pkg::*;
#(
   parameter int TAG_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_v,
   input  logic [TAG_W-1:0] set_tag,
   input  pend_cnt_t        set_cnt,
   input  logic             dec_v,
   input  logic [TAG_W-1:0] dec_tag,
   input  logic             clr_v,
   input  logic [TAG_W-1:0] clr_tag,
   output logic             dec_last
);
   localparam int NTAGS = 1 << TAG_W;

   pend_cnt_t pend_q [NTAGS];

   assign dec_last = dec_v && (pend_q[dec_tag] == 2'd1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NTAGS; i++) begin
            pend_q[i] <= '0;
         end
      end else begin
         if (clr_v) begin
            pend_q[clr_tag] <= '0;
         end
         if (set_v) begin
            pend_q[set_tag] <= set_cnt;
         end
         if (dec_v) begin
            pend_q[dec_tag] <= pend_q[dec_tag] - 2'd1;
         end
      end
   end

   // R6: each drained tag still has an outstanding source
   a_r6_dec_pending : assert property (@(posedge clk) disable iff (!rst_n)
      dec_v |-> (pend_q[dec_tag] != 2'd0));
endmodule

// File: rtl/swu_wakeup_unit.sv
module swu_wakeup_unit
   import swu_pkg::*;
#(
   parameter int NUM_INT_REGS = 16,
   parameter int NUM_FP_REGS  = 16,
   parameter int REG_W        = 6,
   parameter int TAG_W        = 4,
   parameter int LIST_DEPTH   = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ins_valid,
   input  logic [TAG_W-1:0] ins_tag,
   input  logic [REG_W-1:0] ins_src0,
   input  logic             ins_src0_rdy,
   input  logic [REG_W-1:0] ins_src1,
   input  logic             ins_src1_rdy,
   input  logic [REG_W-1:0] ins_dst,
   output logic             ins_stall,
   input  logic             cmp_valid,
   input  logic [REG_W-1:0] cmp_dst,
   input  logic             sq_valid,
   input  logic [TAG_W-1:0] sq_tag,
   output logic             wake_valid,
   output logic [TAG_W-1:0] wake_tag,
   output logic             busy,
   output logic             prod_conflict
);
   localparam int NUM_PHYS = NUM_INT_REGS + NUM_FP_REGS;
   localparam int PIDX_W   = (NUM_PHYS > 1) ? $clog2(NUM_PHYS) : 1;
   localparam int CNT_W    = $clog2(LIST_DEPTH + 1);

   if (LIST_DEPTH < 2) begin : g_bad_depth
      $error("LIST_DEPTH must be at least 2");
   end
   if ((1 << REG_W) < NUM_PHYS) begin : g_bad_regw
      $error("REG_W too narrow for the physical register count");
   end

   function automatic logic in_rng(input logic [REG_W-1:0] idx);
      return int'(idx) < NUM_PHYS;
   endfunction

   logic [NUM_PHYS-1:0] sb_q;
   drain_state_e        dstate_q;
   logic [PIDX_W-1:0]   dreg_q;

   logic [CNT_W-1:0] lst_cnt    [NUM_PHYS];
   logic [TAG_W-1:0] lst_head   [NUM_PHYS];
   logic             lst_head_v [NUM_PHYS];

   logic [PIDX_W-1:0] s0_lo, s1_lo, d_lo, c_lo;
   logic              link0, link1, same_reg, ovf0, ovf1;
   logic              ins_fire, cmp_fire, sq_fire, last_pop, dec_last;
   int                need0;
   pend_cnt_t         npend;

   assign s0_lo = ins_src0[PIDX_W-1:0];
   assign s1_lo = ins_src1[PIDX_W-1:0];
   assign d_lo  = ins_dst[PIDX_W-1:0];
   assign c_lo  = cmp_dst[PIDX_W-1:0];

   assign busy = (dstate_q == DRN_RUN);

   // a source links only when neither hint, range nor scoreboard clears it
   assign link0 = ins_valid && in_rng(ins_src0) && !ins_src0_rdy && !sb_q[s0_lo];
   assign link1 = ins_valid && in_rng(ins_src1) && !ins_src1_rdy && !sb_q[s1_lo];
   assign same_reg = link0 && link1 && (s0_lo == s1_lo);
   assign need0 = same_reg ? 2 : 1;
   assign ovf0 = link0 && ((int'(lst_cnt[s0_lo]) + need0) > LIST_DEPTH);
   assign ovf1 = link1 && ((int'(lst_cnt[s1_lo]) + 1) > LIST_DEPTH);

   assign ins_stall = busy || cmp_valid || sq_valid || ovf0 || ovf1;
   assign ins_fire  = ins_valid && !ins_stall;
   assign npend     = pend_cnt_t'({1'b0, link0}) + pend_cnt_t'({1'b0, link1});

   assign cmp_fire = cmp_valid && !busy && in_rng(cmp_dst);
   assign sq_fire  = sq_valid && !busy;
   assign last_pop = busy && (lst_cnt[dreg_q] == CNT_W'(1));

   for (genvar r = 0; r < NUM_PHYS; r++) begin : g_reg
      logic       hit0, hit1, pop_r;
      logic [1:0] push_n;

      assign hit0   = ins_fire && link0 && (s0_lo == PIDX_W'(r));
      assign hit1   = ins_fire && link1 && (s1_lo == PIDX_W'(r));
      assign push_n = {1'b0, hit0} + {1'b0, hit1};
      assign pop_r  = busy && (dreg_q == PIDX_W'(r));

      swu_dep_list #(
         .TAG_W      (TAG_W),
         .LIST_DEPTH (LIST_DEPTH),
         .CNT_W      (CNT_W)
      ) u_list (
         .clk      (clk),
         .rst_n    (rst_n),
         .push_n   (push_n),
         .push_tag (ins_tag),
         .pop      (pop_r),
         .sq_v     (sq_fire),
         .sq_tag   (sq_tag),
         .cnt      (lst_cnt[r]),
         .head_tag (lst_head[r]),
         .head_v   (lst_head_v[r])
      );
   end

   swu_tag_table #(
      .TAG_W (TAG_W)
   ) u_tags (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_v    (ins_fire && (npend != 2'd0)),
      .set_tag  (ins_tag),
      .set_cnt  (npend),
      .dec_v    (busy),
      .dec_tag  (lst_head[dreg_q]),
      .clr_v    (sq_fire),
      .clr_tag  (sq_tag),
      .dec_last (dec_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sb_q          <= '0;
         dstate_q      <= DRN_IDLE;
         dreg_q        <= '0;
         wake_valid    <= 1'b0;
         wake_tag      <= '0;
         prod_conflict <= 1'b0;
      end else begin
         if (last_pop) begin
            sb_q[dreg_q] <= 1'b1;
            dstate_q     <= DRN_IDLE;
         end
         if (cmp_fire) begin
            if (lst_cnt[c_lo] == '0) begin
               sb_q[c_lo] <= 1'b1;
            end else begin
               dstate_q <= DRN_RUN;
               dreg_q   <= c_lo;
            end
         end
         if (ins_fire && in_rng(ins_dst)) begin
            sb_q[d_lo] <= 1'b0;
         end
         wake_valid    <= (ins_fire && (npend == 2'd0)) || dec_last;
         wake_tag      <= ins_fire ? ins_tag : lst_head[dreg_q];
         prod_conflict <= ins_fire && in_rng(ins_dst) && (lst_cnt[d_lo] != '0);
      end
   end

   // R8: a drain never runs on an empty list
   a_r8_busy_has_work : assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> lst_head_v[dreg_q]);

   // R5: completion beyond the physical range starts no drain
   a_r5_oob_no_drain : assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_valid && !busy && !in_rng(cmp_dst)) |=> !busy);

   // R11: completion and squash are only offered while idle
   a_r11_cmp_idle : assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !(cmp_valid || sq_valid));
endmodule

// File: tb/swu_wakeup_unit_tb_top.sv
`timescale 1ns/1ps
module swu_wakeup_unit_tb_top;
   localparam int REG_W = 4;
   localparam int TAG_W = 3;
   localparam logic [3:0] NONE = 4'd15;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ins_valid = 1'b0;
   logic [TAG_W-1:0] ins_tag = '0;
   logic [REG_W-1:0] ins_src0 = NONE, ins_src1 = NONE, ins_dst = NONE;
   logic ins_src0_rdy = 1'b0, ins_src1_rdy = 1'b0;
   logic ins_stall;
   logic cmp_valid = 1'b0;
   logic [REG_W-1:0] cmp_dst = '0;
   logic sq_valid = 1'b0;
   logic [TAG_W-1:0] sq_tag = '0;
   logic wake_valid, busy, prod_conflict;
   logic [TAG_W-1:0] wake_tag;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   swu_wakeup_unit #(
      .NUM_INT_REGS (4),
      .NUM_FP_REGS  (4),
      .REG_W        (REG_W),
      .TAG_W        (TAG_W),
      .LIST_DEPTH   (4)
   ) dut_i (
      .clk (clk), .rst_n (rst_n),
      .ins_valid (ins_valid), .ins_tag (ins_tag),
      .ins_src0 (ins_src0), .ins_src0_rdy (ins_src0_rdy),
      .ins_src1 (ins_src1), .ins_src1_rdy (ins_src1_rdy),
      .ins_dst (ins_dst), .ins_stall (ins_stall),
      .cmp_valid (cmp_valid), .cmp_dst (cmp_dst),
      .sq_valid (sq_valid), .sq_tag (sq_tag),
      .wake_valid (wake_valid), .wake_tag (wake_tag),
      .busy (busy), .prod_conflict (prod_conflict)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_ins(input int tag, input int s0, input bit r0, input int s1,
                         input bit r1, input int dst, input bit exp_stall,
                         input bit exp_wake, input bit exp_conf, input string req);
      @(negedge clk);
      ins_valid = 1'b1; ins_tag = TAG_W'(tag);
      ins_src0 = REG_W'(s0); ins_src0_rdy = r0;
      ins_src1 = REG_W'(s1); ins_src1_rdy = r1;
      ins_dst = REG_W'(dst);
      #1;
      chk(ins_stall == exp_stall, {req, " stall"}, ins_stall, exp_stall);
      @(negedge clk);
      ins_valid = 1'b0;
      chk(wake_valid == exp_wake, {req, " wake"}, wake_valid, exp_wake);
      if (exp_wake && wake_valid)
         chk(wake_tag == TAG_W'(tag), {req, " tag"}, wake_tag, tag);
      chk(prod_conflict == exp_conf, {req, " conflict"}, prod_conflict, exp_conf);
   endtask

   task automatic do_cmp(input int rg, input int exp_mask, input int exp_n, input string req);
      int cyc = 0;
      logic [7:0] got = '0;
      @(negedge clk);
      cmp_valid = 1'b1; cmp_dst = REG_W'(rg);
      @(negedge clk);
      cmp_valid = 1'b0;
      if (wake_valid) got[wake_tag] = 1'b1;
      while (busy && cyc < 20) begin
         @(negedge clk);
         cyc++;
         if (wake_valid) got[wake_tag] = 1'b1;
      end
      chk(cyc == exp_n, {req, " busy cycles"}, cyc, exp_n);
      chk(int'(got) == exp_mask, {req, " woken set"}, int'(got), exp_mask);
   endtask

   task automatic do_sq(input int tag);
      @(negedge clk);
      sq_valid = 1'b1; sq_tag = TAG_W'(tag);
      @(negedge clk);
      sq_valid = 1'b0;
   endtask

   // mark a register not-ready via a source-free producer (tag 7 wakes at once)
   task automatic unready(input int rg, input string req);
      do_ins(7, NONE, 1'b0, NONE, 1'b0, rg, 1'b0, 1'b1, 1'b0, req);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         tests++; fails++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(wake_valid == 1'b0, "R1 reset wake", wake_valid, 0);
      chk(busy == 1'b0, "R1 reset busy", busy, 0);
      chk(ins_stall == 1'b0, "R1 reset stall", ins_stall, 0);

      // R1: every register starts not-ready; R5: index 15 is a ready source
      for (int r = 0; r < 8; r++)
         do_ins(r, r, 1'b0, NONE, 1'b0, NONE, 1'b0, 1'b0, 1'b0, "R1 sweep");
      for (int r = 0; r < 8; r++)
         do_cmp(r, 1 << r, 1, "R8 single drain");
      // R3 / R12: drained registers now read ready
      for (int r = 0; r < 8; r++)
         do_ins(r, r, 1'b0, NONE, 1'b0, NONE, 1'b0, 1'b1, 1'b0, "R3 scoreboard ready");

      // R4: destination clears the flag
      do_ins(0, NONE, 1'b0, NONE, 1'b0, 2, 1'b0, 1'b1, 1'b0, "R2 no sources");
      do_ins(1, 2, 1'b0, NONE, 1'b0, NONE, 1'b0, 1'b0, 1'b0, "R4 dst cleared");
      do_cmp(2, 8'h02, 1, "R4 drain");

      // R2: ready hint overrides a not-ready scoreboard
      unready(4, "R4 set");
      do_ins(4, 4, 1'b1, NONE, 1'b0, NONE, 1'b0, 1'b1, 1'b0, "R2 ready hint");

      // R5: out-of-range sources and completion
      do_ins(5, 12, 1'b0, 9, 1'b0, NONE, 1'b0, 1'b1, 1'b0, "R5 oob sources");
      do_cmp(12, 0, 0, "R5 oob completion");
      do_ins(6, 4, 1'b0, NONE, 1'b0, NONE, 1'b0, 1'b0, 1'b0, "R5 reg4 still pending");
      do_cmp(4, 8'h40, 1, "R5 reg4 drain");

      // R6: two sources
      unready(5, "R6 set5");
      unready(6, "R6 set6");
      do_ins(2, 5, 1'b0, 6, 1'b0, NONE, 1'b0, 1'b0, 1'b0, "R6 insert");
      do_cmp(5, 0, 1, "R6 first source");
      do_cmp(6, 8'h04, 1, "R6 second source");

      // R8: fill levels 0..4
      for (int n = 0; n <= 4; n++) begin
         unready(7, "R8 set");
         for (int t = 0; t < n; t++)
            do_ins(t, 7, 1'b0, NONE, 1'b0, NONE, 1'b0, 1'b0, 1'b0, "R8 fill");
         do_cmp(7, (1 << n) - 1, n, "R8 drain level");
         do_ins(6, 7, 1'b0, NONE, 1'b0, NONE, 1'b0, 1'b1, 1'b0, "R12 ready after drain");
      end

      // R7: overflow stalls
      unready(7, "R7 set");
      for (int t = 0; t < 4; t++)
         do_ins(t, 7, 1'b0, NONE, 1'b0, NONE, 1'b0, 1'b0, 1'b0, "R7 fill");
      do_ins(4, 7, 1'b0, NONE, 1'b0, NONE, 1'b1, 1'b0, 1'b0, "R7 full list");
      do_cmp(7, 8'h0F, 4, "R7 drain full");
      unready(7, "R7 set2");
      for (int t = 0; t < 3; t++)
         do_ins(t, 7, 1'b0, NONE, 1'b0, NONE, 1'b0, 1'b0, 1'b0, "R7 fill3");
      do_ins(3, 7, 1'b0, 7, 1'b0, NONE, 1'b1, 1'b0, 1'b0, "R7 pair needs two");
      do_ins(3, 7, 1'b0, NONE, 1'b0, NONE, 1'b0, 1'b0, 1'b0, "R7 single fits");
      do_cmp(7, 8'h0F, 4, "R7 drain again");

      // R9: squash
      unready(7, "R9 set");
      for (int t = 0; t < 3; t++)
         do_ins(t, 7, 1'b0, NONE, 1'b0, NONE, 1'b0, 1'b0, 1'b0, "R9 fill");
      do_sq(1);
      do_cmp(7, 8'h05, 2, "R9 squashed skipped");
      unready(5, "R9 set5");
      unready(6, "R9 set6");
      do_ins(4, 5, 1'b0, 6, 1'b0, NONE, 1'b0, 1'b0, 1'b0, "R9 two-src");
      do_sq(4);
      do_cmp(5, 0, 0, "R9 list5 emptied");
      do_cmp(6, 0, 0, "R9 list6 emptied");

      // R10: producer over waiting tags
      unready(3, "R10 set");
      do_ins(0, 3, 1'b0, NONE, 1'b0, NONE, 1'b0, 1'b0, 1'b0, "R10 waiter");
      do_ins(1, NONE, 1'b0, NONE, 1'b0, 3, 1'b0, 1'b1, 1'b1, "R10 conflict");
      do_cmp(3, 8'h01, 1, "R10 drain");

      // R11: stall during completion and drain
      unready(7, "R11 set");
      do_ins(0, 7, 1'b0, NONE, 1'b0, NONE, 1'b0, 1'b0, 1'b0, "R11 fill");
      do_ins(1, 7, 1'b0, NONE, 1'b0, NONE, 1'b0, 1'b0, 1'b0, "R11 fill");
      @(negedge clk);
      cmp_valid = 1'b1; cmp_dst = 4'd7;
      ins_valid = 1'b1; ins_tag = 3'd5; ins_src0 = NONE; ins_src1 = NONE;
      ins_dst = NONE; ins_src0_rdy = 1'b1; ins_src1_rdy = 1'b1;
      #1;
      chk(ins_stall == 1'b1, "R11 stall on completion", ins_stall, 1);
      @(negedge clk);
      cmp_valid = 1'b0;
      chk(busy == 1'b1, "R11 busy", busy, 1);
      chk(ins_stall == 1'b1, "R11 stall while busy", ins_stall, 1);
      @(negedge clk);
      ins_valid = 1'b0;
      chk(wake_valid && wake_tag != 3'd5, "R11 no insert wake", wake_tag, 0);
      @(negedge clk);
      chk(busy == 1'b0, "R11 drain done", busy, 0);
      do_ins(2, 7, 1'b0, NONE, 1'b0, NONE, 1'b0, 1'b1, 1'b0, "R12 ready");

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule